// File: doc/BRIEF.md
# Multi-channel SAR conversion sequencer

This block is the digital control of a successive-approximation converter that scans a range of input channels. A one-cycle request on `start_set` launches a scan. The block then works through channels 0 up to `scan_last` in turn. For each channel it first holds the sample switch closed for a programmed number of cycles. It then runs the bit-by-bit approximation. In each trial cycle it presents a code on `dac_code` and reads back a one-bit comparator decision on `cmp_in`, which is 1 when the analog level is at or above the code. At the end of every channel it writes the result and the channel number to a data register.

The block raises sticky flags at the end of sampling, at the end of a conversion and at the end of a scan. Each flag stays set until software pulses its clear input. The start bit reads 1 for as long as the block is busy. A stop request aborts the work in progress, throws away the partial result and returns the block to idle, so the next scan starts again at channel 0. Timing follows a table of half-cycle phase lengths. A build parameter chooses how those lengths map onto whole clock cycles: either the exact half-cycle total is kept, or each phase is rounded up on its own.

The result is a plain register. It is overwritten at the end of each channel and takes no back-pressure: software or a downstream consumer must read it before the next conversion ends. The sampling code, resolution code, scan range and continuous setting are captured when a start is accepted, and they hold for the whole scan.

Top module: `sar_scan_seq`

## Requirements
- R1: While `rst_n` is low and directly after it, the start bit, the stop bit, the three flags, `data_reg` and `data_ch` all read 0.
- R2: `start_set` is accepted only while the start bit reads 0. After acceptance the start bit reads 1 until the block is idle again. A `start_set` pulse while the start bit is 1 changes neither the channel order nor the timing.
- R3: Sampling lasts ceil(H/2) cycles, where H is the sampling length in half-cycles for `cfg_smp` codes 0..7: 3, 15, 27, 57, 83, 111, 143, 479. At its end `flag_eosmp` is set, and it stays set until a `clr_eosmp` pulse clears it.
- R4: With FINE_TIMING=1, a channel takes (H + A)/2 cycles in total, where A = 2n+1 is the approximation length in half-cycles for n result bits. The approximation phase gets the cycles that the sampling phase leaves over.
- R5: With FINE_TIMING=0, the sampling phase lasts ceil(H/2) cycles and the approximation phase lasts ceil(A/2) = n+1 cycles.
- R6: `cfg_res` codes 0, 1, 2, 3 select n = 12, 10, 8, 6 bits. The result is right-aligned and equals the 12-bit input level shifted right by 12-n. Trial codes are tried MSB first against `cmp_in`.
- R7: `flag_eoc` is set in the same cycle that `data_reg` and `data_ch` take the new result. `data_reg` changes at no other time.
- R8: A scan converts channels 0 to `scan_last` in ascending order. After the last channel `flag_eoseq` is set together with `flag_eoc`, the start bit returns to 0 and the block goes idle.
- R9: With `cfg_cont` set at start, the block sets `flag_eoseq` after the last channel and carries on at channel 0 with no gap, and the start bit stays 1.
- R10: `stop_set` while busy sets the stop bit for exactly one cycle. In the next cycle both the stop bit and the start bit clear. The aborted conversion neither writes `data_reg` nor sets `flag_eoc`.
- R11: The first scan after a stop begins at channel 0.
- R12: `stop_set` while idle is ignored: the stop bit stays 0 and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_set | input | 1 | Software start request, one cycle |
| stop_set | input | 1 | Software stop request, one cycle |
| cfg_smp | input | 3 | Sampling-length code |
| cfg_res | input | 2 | Resolution code |
| cfg_cont | input | 1 | Continuous scanning |
| scan_last | input | CH_W | Last channel of the scan |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| clr_eosmp | input | 1 | Clear end-of-sampling flag |
| clr_eoc | input | 1 | Clear end-of-conversion flag |
| clr_eoseq | input | 1 | Clear end-of-scan flag |
| start_bit | output | 1 | Busy/start status |
| stop_bit | output | 1 | Stop in progress |
| cur_ch | output | CH_W | Channel being sampled or converted |
| sampling | output | 1 | Sample switch closed |
| dac_code | output | 12 | Trial code for the comparator |
| flag_eosmp | output | 1 | End of sampling flag |
| flag_eoc | output | 1 | End of conversion flag |
| flag_eoseq | output | 1 | End of scan flag |
| data_reg | output | 12 | Last result, right-aligned |
| data_ch | output | CH_W | Channel of the last result |

## Verification
The bench builds two instances, both with NUM_CH=8. One has FINE_TIMING=1 and the other FINE_TIMING=0. This lets the bench measure the exact half-cycle totals and the per-phase rounded lengths side by side, with the same sampling and resolution codes. Eight channels carry distinct input levels, so each result also identifies its channel. The longest sampling code, a full eight-channel scan and the all-ones and all-zeros levels all fit within a short run.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int DATA_W = 12;
  localparam int SMP_W  = 3;
  localparam int RES_W  = 2;
  localparam int PH_W   = 10;
  localparam int BITS_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2,
    ST_STOP    = 2'd3
  } seq_state_e;

  // sampling length in half clock periods per code
  function automatic logic [PH_W-1:0] smp_half(input logic [SMP_W-1:0] code);
    logic [PH_W-1:0] h;
    case (code)
      3'd0:    h = 10'd3;
      3'd1:    h = 10'd15;
      3'd2:    h = 10'd27;
      3'd3:    h = 10'd57;
      3'd4:    h = 10'd83;
      3'd5:    h = 10'd111;
      3'd6:    h = 10'd143;
      default: h = 10'd479;
    endcase
    return h;
  endfunction

  function automatic logic [BITS_W-1:0] res_bits(input logic [RES_W-1:0] code);
    return BITS_W'(DATA_W - 2 * int'(code));
  endfunction

  // approximation length in half periods: 2n+1
  function automatic logic [PH_W-1:0] res_half(input logic [RES_W-1:0] code);
    return PH_W'({res_bits(code), 1'b1});
  endfunction
endpackage

// File: rtl/sar_phase_timer.sv
module sar_phase_timer
  import sar_seq_pkg::*;
#(
  parameter bit FINE_TIMING = 1'b1
) (
  input  logic [SMP_W-1:0]  smp_code,
  input  logic [RES_W-1:0]  res_code,
  output logic [PH_W-1:0]   smp_cycles,
  output logic [PH_W-1:0]   cnv_cycles,
  output logic [BITS_W-1:0] nbits
);
  logic [PH_W-1:0] sh;
  logic [PH_W-1:0] rh;

  assign sh         = smp_half(smp_code);
  assign rh         = res_half(res_code);
  assign nbits      = res_bits(res_code);
  assign smp_cycles = (sh + PH_W'(1)) >> 1;

  generate
    if (FINE_TIMING) begin : g_fine
      logic [PH_W-1:0] total;
      assign total      = (sh + rh) >> 1;
      assign cnv_cycles = total - smp_cycles;
    end else begin : g_round
      assign cnv_cycles = (rh + PH_W'(1)) >> 1;
    end
  endgenerate
endmodule

// File: rtl/sar_approx.sv
module sar_approx
  import sar_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              step,
  input  logic [BITS_W-1:0] nbits,
  input  logic              cmp_in,
  output logic [DATA_W-1:0] dac_code,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] acc_nx;
  logic [BITS_W-1:0] left_q;
  logic              trial;

  assign trial    = step && (left_q != '0);
  assign dac_code = trial ? (acc_q | mask_q) : acc_q;
  assign acc_nx   = (trial && cmp_in) ? (acc_q | mask_q) : acc_q;
  assign result   = acc_nx >> (BITS_W'(DATA_W) - nbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mask_q <= '0;
      left_q <= '0;
    end else if (init) begin
      acc_q  <= '0;
      mask_q <= {1'b1, {(DATA_W-1){1'b0}}};
      left_q <= nbits;
    end else if (trial) begin
      acc_q  <= acc_nx;
      mask_q <= mask_q >> 1;
      left_q <= left_q - BITS_W'(1);
    end
  end
endmodule

// File: rtl/sar_flag.sv
module sar_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_set,
  input  logic            stop_set,
  input  logic            cfg_cont,
  input  logic [CH_W-1:0] scan_last,
  input  logic [PH_W-1:0] smp_cycles,
  input  logic [PH_W-1:0] cnv_cycles,
  output seq_state_e      state,
  output logic [CH_W-1:0] cur_ch,
  output logic            accept,
  output logic            smp_end,
  output logic            cnv_end,
  output logic            seq_end
);
  seq_state_e      state_q;
  logic [PH_W-1:0] cnt_q;
  logic [CH_W-1:0] ch_q;
  logic [CH_W-1:0] last_q;
  logic            cont_q;
  logic            busy;
  logic            abort;
  logic            smp_done;
  logic            cnv_done;

  assign busy     = (state_q == ST_SAMPLE) || (state_q == ST_CONVERT);
  assign abort    = busy && stop_set;
  assign accept   = (state_q == ST_IDLE) && start_set;
  assign smp_done = (state_q == ST_SAMPLE) && (cnt_q == smp_cycles - PH_W'(1));
  assign cnv_done = (state_q == ST_CONVERT) && (cnt_q == cnv_cycles - PH_W'(1));
  assign smp_end  = smp_done && !stop_set;
  assign cnv_end  = cnv_done && !stop_set;
  assign seq_end  = cnv_end && (ch_q == last_q);
  assign state    = state_q;
  assign cur_ch   = ch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
      last_q  <= '0;
      cont_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_SAMPLE;
            cnt_q   <= '0;
            ch_q    <= '0;
            last_q  <= scan_last;
            cont_q  <= cfg_cont;
          end
        end
        ST_SAMPLE: begin
          if (abort) begin
            state_q <= ST_STOP;
          end else if (smp_done) begin
            state_q <= ST_CONVERT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + PH_W'(1);
          end
        end
        ST_CONVERT: begin
          if (abort) begin
            state_q <= ST_STOP;
          end else if (cnv_done) begin
            cnt_q <= '0;
            if (ch_q == last_q) begin
              ch_q    <= '0;
              state_q <= cont_q ? ST_SAMPLE : ST_IDLE;
            end else begin
              ch_q    <= ch_q + CH_W'(1);
              state_q <= ST_SAMPLE;
            end
          end else begin
            cnt_q <= cnt_q + PH_W'(1);
          end
        end
        default: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
          ch_q    <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sar_scan_seq.sv
module sar_scan_seq
  import sar_seq_pkg::*;
#(
  parameter int  NUM_CH      = 8,
  parameter bit  FINE_TIMING = 1'b1,
  localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_set,
  input  logic              stop_set,
  input  logic [SMP_W-1:0]  cfg_smp,
  input  logic [RES_W-1:0]  cfg_res,
  input  logic              cfg_cont,
  input  logic [CH_W-1:0]   scan_last,
  input  logic              cmp_in,
  input  logic              clr_eosmp,
  input  logic              clr_eoc,
  input  logic              clr_eoseq,
  output logic              start_bit,
  output logic              stop_bit,
  output logic [CH_W-1:0]   cur_ch,
  output logic              sampling,
  output logic [DATA_W-1:0] dac_code,
  output logic              flag_eosmp,
  output logic              flag_eoc,
  output logic              flag_eoseq,
  output logic [DATA_W-1:0] data_reg,
  output logic [CH_W-1:0]   data_ch
);
  localparam int NFLAG = 3;

  seq_state_e        state;
  logic              accept;
  logic              smp_end;
  logic              cnv_end;
  logic              seq_end;
  logic [SMP_W-1:0]  smp_q;
  logic [RES_W-1:0]  res_q;
  logic [PH_W-1:0]   smp_cycles;
  logic [PH_W-1:0]   cnv_cycles;
  logic [BITS_W-1:0] nbits;
  logic [DATA_W-1:0] result;
  logic [DATA_W-1:0] data_q;
  logic [CH_W-1:0]   dch_q;
  logic [NFLAG-1:0]  f_set;
  logic [NFLAG-1:0]  f_clr;
  logic [NFLAG-1:0]  f_q;

  sar_phase_timer #(.FINE_TIMING(FINE_TIMING)) u_timer (
    .smp_code   (smp_q),
    .res_code   (res_q),
    .smp_cycles (smp_cycles),
    .cnv_cycles (cnv_cycles),
    .nbits      (nbits)
  );

  sar_seq_fsm #(.CH_W(CH_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_set  (start_set),
    .stop_set   (stop_set),
    .cfg_cont   (cfg_cont),
    .scan_last  (scan_last),
    .smp_cycles (smp_cycles),
    .cnv_cycles (cnv_cycles),
    .state      (state),
    .cur_ch     (cur_ch),
    .accept     (accept),
    .smp_end    (smp_end),
    .cnv_end    (cnv_end),
    .seq_end    (seq_end)
  );

  sar_approx u_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (state == ST_SAMPLE),
    .step     (state == ST_CONVERT),
    .nbits    (nbits),
    .cmp_in   (cmp_in),
    .dac_code (dac_code),
    .result   (result)
  );

  assign f_set = {seq_end, cnv_end, smp_end};
  assign f_clr = {clr_eoseq, clr_eoc, clr_eosmp};

  generate
    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
      sar_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (f_set[gi]),
        .clr   (f_clr[gi]),
        .q     (f_q[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= '0;
      res_q  <= '0;
      data_q <= '0;
      dch_q  <= '0;
    end else begin
      if (accept) begin
        smp_q <= cfg_smp;
        res_q <= cfg_res;
      end
      if (cnv_end) begin
        data_q <= result;
        dch_q  <= cur_ch;
      end
    end
  end

  assign start_bit  = (state != ST_IDLE);
  assign stop_bit   = (state == ST_STOP);
  assign sampling   = (state == ST_SAMPLE);
  assign flag_eosmp = f_q[0];
  assign flag_eoc   = f_q[1];
  assign flag_eoseq = f_q[2];
  assign data_reg   = data_q;
  assign data_ch    = dch_q;
endmodule

// File: rtl/sar_scan_seq_chk.sv
module sar_scan_seq_chk
  import sar_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              stop_set,
  input logic              start_bit,
  input logic              stop_bit,
  input logic              flag_eosmp,
  input logic              flag_eoc,
  input logic              flag_eoseq,
  input logic [DATA_W-1:0] data_reg
);
  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_bit |=> (!stop_bit && !start_bit)); // R10
  AST_STOP_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_set && !start_bit) |=> !stop_bit); // R12
  AST_DATA_ONLY_AT_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_reg) |-> flag_eoc); // R7
  AST_EOSMP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_eosmp) |-> start_bit); // R3
  AST_EOSEQ_WITH_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_eoseq) |-> flag_eoc); // R8
endmodule

bind sar_scan_seq sar_scan_seq_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_set   (stop_set),
  .start_bit  (start_bit),
  .stop_bit   (stop_bit),
  .flag_eosmp (flag_eosmp),
  .flag_eoc   (flag_eoc),
  .flag_eoseq (flag_eoseq),
  .data_reg   (data_reg)
);

// File: tb/test_sar_scan_seq.sv
module test_sar_scan_seq;
  localparam int NUM_CH = 8;
  localparam int CH_W   = 3;

  typedef struct {
    int ch;
    int data;
    int when;
  } item_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            start_set = 1'b0;
  logic            stop_set = 1'b0;
  logic            start_set_r = 1'b0;
  logic [2:0]      cfg_smp = '0;
  logic [1:0]      cfg_res = '0;
  logic            cfg_cont = 1'b0;
  logic [CH_W-1:0] scan_last = '0;
  logic            clr_eosmp = 1'b0;
  logic            clr_eoc = 1'b0;
  logic            clr_eoseq = 1'b0;

  logic            start_bit_a, stop_bit_a, sampling_a, eosmp_a, eoc_a, eoseq_a;
  logic [CH_W-1:0] cur_ch_a, data_ch_a;
  logic [11:0]     dac_a, data_a;
  logic            start_bit_r, stop_bit_r, sampling_r, eosmp_r, eoc_r, eoseq_r;
  logic [CH_W-1:0] cur_ch_r, data_ch_r;
  logic [11:0]     dac_r, data_r;

  logic [11:0] ain [NUM_CH];
  logic        cmp_a, cmp_r;
  assign cmp_a = (ain[cur_ch_a] >= dac_a);
  assign cmp_r = (ain[cur_ch_r] >= dac_r);

  int    cyc = 0;
  int    n_checks = 0;
  int    n_errors = 0;
  item_t exp_q[$];
  int    smp_base = 0;
  int    smp_period = 1;
  int    smp_k = 0;

  always @(posedge clk) cyc <= cyc + 1;

  sar_scan_seq #(.NUM_CH(NUM_CH), .FINE_TIMING(1'b1)) i_sar_scan_seq (
    .clk(clk), .rst_n(rst_n), .start_set(start_set), .stop_set(stop_set),
    .cfg_smp(cfg_smp), .cfg_res(cfg_res), .cfg_cont(cfg_cont), .scan_last(scan_last),
    .cmp_in(cmp_a), .clr_eosmp(clr_eosmp), .clr_eoc(clr_eoc), .clr_eoseq(clr_eoseq),
    .start_bit(start_bit_a), .stop_bit(stop_bit_a), .cur_ch(cur_ch_a), .sampling(sampling_a),
    .dac_code(dac_a), .flag_eosmp(eosmp_a), .flag_eoc(eoc_a), .flag_eoseq(eoseq_a),
    .data_reg(data_a), .data_ch(data_ch_a)
  );

  sar_scan_seq #(.NUM_CH(NUM_CH), .FINE_TIMING(1'b0)) i_sar_scan_seq_rnd (
    .clk(clk), .rst_n(rst_n), .start_set(start_set_r), .stop_set(1'b0),
    .cfg_smp(cfg_smp), .cfg_res(cfg_res), .cfg_cont(cfg_cont), .scan_last(scan_last),
    .cmp_in(cmp_r), .clr_eosmp(1'b0), .clr_eoc(1'b0), .clr_eoseq(1'b0),
    .start_bit(start_bit_r), .stop_bit(stop_bit_r), .cur_ch(cur_ch_r), .sampling(sampling_r),
    .dac_code(dac_r), .flag_eosmp(eosmp_r), .flag_eoc(eoc_r), .flag_eoseq(eoseq_r),
    .data_reg(data_r), .data_ch(data_ch_r)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  function automatic int half_smp(input int code);
    case (code)
      0: return 3;
      1: return 15;
      2: return 27;
      3: return 57;
      4: return 83;
      5: return 111;
      6: return 143;
      default: return 479;
    endcase
  endfunction

  // monitor: end-of-conversion results against the scoreboard (R4, R6, R7, R8)
  always @(negedge clk) begin
    item_t it;
    if (rst_n && eoc_a && !clr_eoc) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected end of conversion", cyc, -1);
      end else begin
        it = exp_q.pop_front();
        check(int'(data_ch_a) == it.ch, "R8", "result channel", int'(data_ch_a), it.ch);
        check(int'(data_a) == it.data, "R6", "result value", int'(data_a), it.data);
        check(cyc == it.when, "R4", "end of conversion cycle", cyc, it.when);
      end
      clr_eoc <= 1'b1;
    end else begin
      clr_eoc <= 1'b0;
    end
  end

  // monitor: end-of-sampling timing and software clear (R3)
  always @(negedge clk) begin
    if (rst_n && eosmp_a && !clr_eosmp) begin
      check(cyc == smp_base + smp_k * smp_period, "R3", "end of sampling cycle",
            cyc, smp_base + smp_k * smp_period);
      smp_k <= smp_k + 1;
      clr_eosmp <= 1'b1;
    end else begin
      clr_eosmp <= 1'b0;
    end
  end

  task automatic run_scan(input int smp, input int res, input int last, input bit cont,
                          input int nres, input bit poke);
    int s, c, bits, t0;
    s    = (half_smp(smp) + 1) / 2;
    bits = 12 - 2 * res;
    c    = (half_smp(smp) + 2 * bits + 1) / 2 - s;
    @(negedge clk);
    cfg_smp   = smp[2:0];
    cfg_res   = res[1:0];
    scan_last = last[CH_W-1:0];
    cfg_cont  = cont;
    t0        = cyc;
    smp_base  = t0 + 1 + s;
    smp_period = s + c;
    smp_k     = 0;
    for (int k = 0; k < nres; k++) begin
      item_t it;
      it.ch   = k % (last + 1);
      it.data = int'(ain[it.ch]) >> (12 - bits);
      it.when = t0 + 1 + (k + 1) * (s + c);
      exp_q.push_back(it);
    end
    start_set = 1'b1;
    @(negedge clk);
    start_set = 1'b0;
    check(start_bit_a == 1'b1, "R2", "start bit after launch", int'(start_bit_a), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      start_set = 1'b1;
      @(negedge clk);
      start_set = 1'b0;
      check(start_bit_a == 1'b1, "R2", "start bit after ignored start", int'(start_bit_a), 1);
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic end_of_scan_check();
    check(eoseq_a == 1'b1, "R8", "end of scan flag", int'(eoseq_a), 1);
    check(start_bit_a == 1'b0, "R8", "start bit after scan", int'(start_bit_a), 0);
    clr_eoseq = 1'b1;
    @(negedge clk);
    clr_eoseq = 1'b0;
    check(eoseq_a == 1'b0, "R8", "end of scan flag cleared", int'(eoseq_a), 0);
  endtask

  task automatic stop_now();
    stop_set = 1'b1;
    @(negedge clk);
    stop_set = 1'b0;
    check(stop_bit_a == 1'b1, "R10", "stop bit set", int'(stop_bit_a), 1);
    check(start_bit_a == 1'b1, "R10", "start bit during stop", int'(start_bit_a), 1);
    @(negedge clk);
    check(stop_bit_a == 1'b0, "R10", "stop bit cleared", int'(stop_bit_a), 0);
    check(start_bit_a == 1'b0, "R10", "start bit cleared by stop", int'(start_bit_a), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int keep, kch, t0, got_smp, got_eoc;
    ain[0] = 12'hA5C; ain[1] = 12'h3F1; ain[2] = 12'hFFF; ain[3] = 12'h000;
    ain[4] = 12'h800; ain[5] = 12'h7FF; ain[6] = 12'h123; ain[7] = 12'hC3A;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(start_bit_a == 1'b0 && stop_bit_a == 1'b0, "R1", "control bits in reset",
          int'({start_bit_a, stop_bit_a}), 0);
    check({eosmp_a, eoc_a, eoseq_a} == 3'b000, "R1", "flags in reset",
          int'({eosmp_a, eoc_a, eoseq_a}), 0);
    check(data_a == 12'd0 && data_ch_a == '0, "R1", "data in reset", int'(data_a), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(start_bit_a == 1'b0 && data_a == 12'd0, "R1", "state after reset", int'(data_a), 0);

    // R12: stop while idle
    stop_set = 1'b1;
    @(negedge clk);
    stop_set = 1'b0;
    check(stop_bit_a == 1'b0, "R12", "stop bit while idle", int'(stop_bit_a), 0);
    check({eosmp_a, eoc_a, eoseq_a} == 3'b000, "R12", "flags after idle stop",
          int'({eosmp_a, eoc_a, eoseq_a}), 0);

    // R4 R6 R7 R8: 12-bit scan of three channels
    run_scan(0, 0, 2, 1'b0, 3, 1'b0);
    end_of_scan_check();
    // R2: 10-bit scan with an extra start while busy
    run_scan(1, 1, 4, 1'b0, 5, 1'b1);
    end_of_scan_check();
    // R6: 6-bit scan of all eight channels
    run_scan(2, 3, 7, 1'b0, 8, 1'b0);
    end_of_scan_check();
    // R3: longest sampling code, 8-bit
    run_scan(7, 2, 0, 1'b0, 1, 1'b0);
    end_of_scan_check();

    // R9: continuous scan over two channels, then stop (R10)
    run_scan(0, 1, 1, 1'b1, 5, 1'b0);
    check(eoseq_a == 1'b1, "R9", "end of scan flag in continuous mode", int'(eoseq_a), 1);
    check(start_bit_a == 1'b1, "R9", "still busy after wrap", int'(start_bit_a), 1);
    keep = int'(data_a);
    stop_now();
    repeat (30) @(negedge clk);
    check(int'(data_a) == keep, "R10", "data kept after stop", int'(data_a), keep);
    clr_eoseq = 1'b1;
    @(negedge clk);
    clr_eoseq = 1'b0;

    // R10 R11: abort in the middle of a conversion, then restart at channel 0
    run_scan(0, 0, 3, 1'b0, 1, 1'b0);
    repeat (4) @(negedge clk);
    keep = int'(data_a);
    kch  = int'(data_ch_a);
    stop_now();
    repeat (20) @(negedge clk);
    check(int'(data_a) == keep, "R10", "aborted result discarded", int'(data_a), keep);
    check(int'(data_ch_a) == kch, "R10", "channel kept after abort", int'(data_ch_a), kch);
    check(eoseq_a == 1'b0, "R10", "no end of scan after abort", int'(eoseq_a), 0);
    run_scan(0, 0, 3, 1'b0, 4, 1'b0);  // R11: first item must be channel 0
    end_of_scan_check();

    // R5: rounded timing instance, sampling code 1, 10-bit
    while (start_bit_r) @(negedge clk);
    @(negedge clk);
    cfg_smp = 3'd1; cfg_res = 2'd1; scan_last = '0; cfg_cont = 1'b0;
    t0 = cyc;
    start_set_r = 1'b1;
    @(negedge clk);
    start_set_r = 1'b0;
    got_smp = -1;
    got_eoc = -1;
    repeat (60) begin
      if (eosmp_r && got_smp < 0) got_smp = cyc;
      if (eoc_r && got_eoc < 0) got_eoc = cyc;
      @(negedge clk);
    end
    check(got_smp == t0 + 1 + 8, "R5", "rounded end of sampling", got_smp, t0 + 9);
    check(got_eoc == t0 + 1 + 8 + 11, "R5", "rounded end of conversion", got_eoc, t0 + 20);
    check(int'(data_r) == (int'(ain[0]) >> 2), "R6", "rounded result value",
          int'(data_r), int'(ain[0]) >> 2);
    check(eoseq_r == 1'b1 && start_bit_r == 1'b0, "R8", "rounded scan end",
          int'({eoseq_r, start_bit_r}), 2);

    finish_run();
  end
endmodule